// File: doc/BRIEF.md
# Staged-Commit Video Digitizer Control Bank

This block holds the run-time settings of a three-channel video digitizer: one sampling-phase value, a gain per colour channel and an offset per colour channel. A host writes bytes through a plain port made of an address, a data byte and a write strobe. It reads bytes back through a registered read path. The serial link that carries these accesses sits outside the block.

The phase setting takes effect on the write. Gain and offset writes land in shadow storage first. A shadow reaches its live output only when the paired commit address is written. This lets the host update a channel's setting as one step, without the converter seeing a half-written value. The live outputs hold their reset defaults until the first commit.

For gain, the commit address is the one just above the gain address, and only a zero data byte commits. For offset, the channel value is nine bits wide. The upper eight bits come from one address. The write to the following address supplies the low bit from its data bit 7, and that same write commits the whole value.

Top module: `vdig_cfg_bank`

## Requirements
- R1: A write to address 0x04 loads the phase output from data bits 7:3 at that clock edge. The phase output changes only on such a write. Its default is 16.
- R2: A write to 0x05, 0x07 or 0x09 (red, green, blue) stores data bits 6:0 in that channel's gain shadow. Data bit 7 is dropped. The live gain output does not change.
- R3: A write of 0x00 to 0x06, 0x08 or 0x0A copies the matching gain shadow to the live gain output. The output shows the new value in the cycle after the write.
- R4: A write of a non-zero byte to a gain commit address leaves both the live gain and the gain shadow unchanged.
- R5: A write to 0x0B, 0x0D or 0x0F stores the data byte as bits 8:1 of that channel's offset shadow. The live offset does not change.
- R6: A write to 0x0C, 0x0E or 0x10 takes data bit 7 as offset bit 0. It commits all nine shadow bits to the live offset in the cycle after the write. The upper bits come from the last upper-byte write, or from the default if there has been none.
- R7: The read data shows, one cycle after the address is applied, the shadow contents in register bit positions. Phase is in bits 7:3. Gain is in bits 6:0. The offset upper byte is at its own address. The offset low bit is in bit 7 of the following address. Every other address, including the gain commit addresses, reads 0x00.
- R8: A synchronous active-high reset sets phase to 16, every gain shadow and live gain to 64, and every offset shadow and live offset to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data (shadow view) |
| phase | output | 5 | Live sampling phase |
| gain_r | output | 7 | Live red gain |
| gain_g | output | 7 | Live green gain |
| gain_b | output | 7 | Live blue gain |
| offset_r | output | 9 | Live red offset |
| offset_g | output | 9 | Live green offset |
| offset_b | output | 9 | Live blue offset |

## Verification
The hardest case to reach is a low-bit-only offset commit, where the upper byte of the shadow comes from an earlier upper-byte write. The stimulus therefore writes the blue low-bit address twice, with bit 7 first clear and then set. The second commit must reuse the upper byte from before. A pending gain shadow can only be seen through the read path, because a non-zero commit keeps the shadow value. So the bench reads back shadows that have not been committed, while the live outputs still hold their old values.

// File: rtl/vdig_cfg_pkg.sv
package vdig_cfg_pkg;
  localparam logic [7:0] ADR_PHASE = 8'h04;
  localparam logic [7:0] ADR_GAIN0 = 8'h05;
  localparam logic [7:0] ADR_OFS0  = 8'h0B;
  localparam int         CH_STEP   = 2;
endpackage

// File: rtl/gain_slot.sv
module gain_slot #(
  parameter int         DW     = 8,
  parameter int         W      = 7,
  parameter logic [W-1:0] DEF  = 7'd64,
  parameter logic [7:0] SH_ADR = 8'h05
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  shad,
  output logic [W-1:0]  live
);
  localparam logic [7:0] CM_ADR = SH_ADR + 8'd1;

  logic hit_sh, hit_cm, cm_zero;
  assign hit_sh  = wr_en && (addr == SH_ADR);
  assign hit_cm  = wr_en && (addr == CM_ADR);
  assign cm_zero = (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shad <= DEF;
      live <= DEF;
    end else begin
      if (hit_sh)            shad <= wdata[W-1:0];
      if (hit_cm && cm_zero) live <= shad;
    end
  end

  // R2: no committing write, live gain holds
  a_r2_gain_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == CM_ADR && wdata == '0) |=> $stable(live));
  // R3: zero commit moves the shadow to live
  a_r3_commit_copy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CM_ADR && wdata == '0) |=> (live == $past(shad)));
  // R4: non-zero commit keeps both live and shadow
  a_r4_nonzero_keep: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CM_ADR && wdata != '0) |=> ($stable(live) && $stable(shad)));
endmodule

// File: rtl/offset_slot.sv
module offset_slot #(
  parameter int           DW      = 8,
  parameter int           W       = 9,
  parameter logic [W-1:0] DEF     = 9'd256,
  parameter logic [7:0]   HI_ADR  = 8'h0B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  shad,
  output logic [W-1:0]  live
);
  localparam logic [7:0] LO_ADR = HI_ADR + 8'd1;

  logic hit_hi, hit_lo;
  assign hit_hi = wr_en && (addr == HI_ADR);
  assign hit_lo = wr_en && (addr == LO_ADR);

  always_ff @(posedge clk) begin
    if (rst) begin
      shad <= DEF;
      live <= DEF;
    end else begin
      if (hit_hi) shad[W-1:1] <= wdata[W-2:0];
      if (hit_lo) begin
        shad[0] <= wdata[DW-1];
        live    <= {shad[W-1:1], wdata[DW-1]};
      end
    end
  end

  // R5: an upper-byte write never touches the live offset
  a_r5_hi_held: assert property (@(posedge clk) disable iff (rst)
    hit_hi |=> $stable(live));
  // R6: low write sets live bit 0 from data bit 7
  a_r6_lo_commit: assert property (@(posedge clk) disable iff (rst)
    hit_lo |=> (live[0] == $past(wdata[DW-1])));
  // R6: without a low write the live offset holds
  a_r6_no_lo_hold: assert property (@(posedge clk) disable iff (rst)
    !hit_lo |=> $stable(live));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import vdig_cfg_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 3,
  parameter int PW  = 5,
  parameter int GW  = 7,
  parameter int OW  = 9
) (
  input  logic [7:0]              addr,
  input  logic [PW-1:0]           phase,
  input  logic [NCH-1:0][GW-1:0]  gsh,
  input  logic [NCH-1:0][OW-1:0]  osh,
  output logic [DW-1:0]           rd
);
  always_comb begin
    rd = '0;
    if (addr == ADR_PHASE) rd[DW-1 -: PW] = phase;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADR_GAIN0 + 8'(CH_STEP * c))        rd[GW-1:0] = gsh[c];
      if (addr == ADR_OFS0 + 8'(CH_STEP * c))         rd = osh[c][OW-1:1];
      if (addr == ADR_OFS0 + 8'(CH_STEP * c + 1))     rd[DW-1] = osh[c][0];
    end
  end
endmodule

// File: rtl/vdig_cfg_bank.sv
module vdig_cfg_bank
  import vdig_cfg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PW       = 5,
  parameter int GW       = 7,
  parameter int OW       = 9,
  parameter int PH_DEF   = 16,
  parameter int GAIN_DEF = 64,
  parameter int OFS_DEF  = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [PW-1:0] phase,
  output logic [GW-1:0] gain_r,
  output logic [GW-1:0] gain_g,
  output logic [GW-1:0] gain_b,
  output logic [OW-1:0] offset_r,
  output logic [OW-1:0] offset_g,
  output logic [OW-1:0] offset_b
);
  localparam int NCH = 3;

  logic [PW-1:0]          phase_q;
  logic [NCH-1:0][GW-1:0] g_sh, g_lv;
  logic [NCH-1:0][OW-1:0] o_sh, o_lv;
  logic [DW-1:0]          rd_c;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PW'(PH_DEF);
    else if (wr_en && addr == ADR_PHASE) phase_q <= wdata[DW-1 -: PW];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gain_slot #(
      .DW(DW), .W(GW), .DEF(GW'(GAIN_DEF)),
      .SH_ADR(ADR_GAIN0 + 8'(CH_STEP * c))
    ) u_gain (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .shad(g_sh[c]), .live(g_lv[c])
    );
    offset_slot #(
      .DW(DW), .W(OW), .DEF(OW'(OFS_DEF)),
      .HI_ADR(ADR_OFS0 + 8'(CH_STEP * c))
    ) u_ofs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .shad(o_sh[c]), .live(o_lv[c])
    );
  end

  cfg_read_mux #(.DW(DW), .NCH(NCH), .PW(PW), .GW(GW), .OW(OW)) u_rd (
    .addr(addr), .phase(phase_q), .gsh(g_sh), .osh(o_sh), .rd(rd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_c;
  end

  assign phase    = phase_q;
  assign gain_r   = g_lv[0];
  assign gain_g   = g_lv[1];
  assign gain_b   = g_lv[2];
  assign offset_r = o_lv[0];
  assign offset_g = o_lv[1];
  assign offset_b = o_lv[2];

  // R1: phase moves only on a phase-address write
  a_r1_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADR_PHASE) |=> $stable(phase));
  // R1: a phase write lands from data bits 7:3
  a_r1_phase_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_PHASE) |=> (phase == $past(wdata[DW-1 -: PW])));
  // R7: commit addresses read as zero
  a_r7_commit_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h06 || addr == 8'h08 || addr == 8'h0A) |=> (rdata == '0));
endmodule

// File: tb/sim_vdig_cfg_bank.sv
module sim_vdig_cfg_bank;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [4:0] phase;
  logic [6:0] gain_r, gain_g, gain_b;
  logic [8:0] offset_r, offset_g, offset_b;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  vdig_cfg_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .phase(phase), .gain_r(gain_r), .gain_g(gain_g),
    .gain_b(gain_b), .offset_r(offset_r), .offset_g(offset_g), .offset_b(offset_b)
  );

  // entry: {addr, data, select(4), expected(12)}
  localparam logic [31:0] TBL [15] = '{
    32'h04A8_0015, 32'h0515_1040, 32'h0600_1015, 32'h077F_2040,
    32'h0801_2040, 32'h0800_207F, 32'h0980_3040, 32'h0A00_3000,
    32'h0B12_4100, 32'h0C80_4025, 32'h0DFF_5100, 32'h0E00_51FE,
    32'h0F01_6100, 32'h107F_6002, 32'h1080_6003
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); wr_en = 1'b0; addr = a;
    @(negedge clk);
  endtask

  function automatic int pick(input logic [3:0] s);
    case (s)
      4'd0: pick = phase;
      4'd1: pick = gain_r;
      4'd2: pick = gain_g;
      4'd3: pick = gain_b;
      4'd4: pick = offset_r;
      4'd5: pick = offset_g;
      default: pick = offset_b;
    endcase
  endfunction

  function automatic string tag(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h04) tag = "R1";
    else if (a == 8'h05 || a == 8'h07 || a == 8'h09) tag = "R2";
    else if (a == 8'h06 || a == 8'h08 || a == 8'h0A) tag = (d == 0) ? "R3" : "R4";
    else if (a == 8'h0B || a == 8'h0D || a == 8'h0F) tag = "R5";
    else tag = "R6";
  endfunction

  task automatic check_defaults(input string req);
    chk(req, phase, 16);
    chk(req, gain_r, 64); chk(req, gain_g, 64); chk(req, gain_b, 64);
    chk(req, offset_r, 256); chk(req, offset_g, 256); chk(req, offset_b, 256);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_defaults("R8 reset");

    for (int i = 0; i < 15; i++) begin
      wr(TBL[i][31:24], TBL[i][23:16]);
      chk(tag(TBL[i][31:24], TBL[i][23:16]), pick(TBL[i][15:12]), int'(TBL[i][11:0]));
    end

    // R7 read-back of shadows; pending gain visible before commit
    wr(8'h05, 8'h33);
    chk("R2 pending", gain_r, 21);
    rd(8'h05); chk("R7 gain shadow", rdata, 8'h33);
    rd(8'h04); chk("R7 phase", rdata, 8'hA8);
    rd(8'h0C); chk("R7 ofs lsb", rdata, 8'h80);
    rd(8'h0D); chk("R7 ofs msb", rdata, 8'hFF);
    rd(8'h06); chk("R7 commit addr", rdata, 8'h00);
    rd(8'h20); chk("R7 unmapped", rdata, 8'h00);

    // R4 non-zero commit keeps shadow
    wr(8'h06, 8'h80);
    chk("R4 live", gain_r, 21);
    rd(8'h05); chk("R4 shadow kept", rdata, 8'h33);
    wr(8'h06, 8'h00); chk("R3 late commit", gain_r, 8'h33);

    // R8 synchronous reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_defaults("R8 mid reset");
    rd(8'h05); chk("R8 shadow", rdata, 8'h40);
    rd(8'h0B); chk("R8 ofs shadow", rdata, 8'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule